// File: doc/BRIEF.md
# Checkpointed Row Counter File

This block keeps row pointers into three register-file operands for three independent threads: a 6-bit pointer for operand A, a 6-bit pointer for operand B and a 10-bit pointer for the destination. Each pointer has a checkpoint copy of equal width that serves as a saved base. A thread-index input picks which thread an instruction updates and which thread's pointers drive the address outputs. All pointer arithmetic wraps at the pointer width.

Two instruction forms arrive as a 30-bit word with a valid strobe, one per cycle. A load form writes a value into a pointer and its checkpoint together. That value can be taken as is, added to the checkpoint, or (for the destination only) added to the live pointer. An add form advances a pointer directly, or advances its checkpoint and copies the result to the pointer. The load form can also raise one-cycle release pulses for the operand A and B banks. The block turns the selected thread's pointers into block-aligned row addresses for a matrix-multiply fetch. It also produces a row and a column for one lane of a vector load or store.

Top module: `rowctr_file`

## Requirements
- R1: After reset every live pointer and every checkpoint of every thread is zero. A checkpoint-relative add of zero then reads back zero.
- R2: The load form uses opcode 0x37 in bits 29:24, bank bits in 23:22, mode bits in 21:18, and values for destination, B and A in 17:14, 13:10 and 9:6. Its mask sits in bits 5:0. Mask bit 0, 1 or 2 writes the zero-extended value into both the live pointer and the checkpoint of A, B or the destination, and the result shows on the cycle after acceptance.
- R3: In the load form, mode bit 0, 1 or 2 adds the value to the old checkpoint of A, B or the destination before the write. The addition wraps modulo 64 or 1024.
- R4: In the load form, mode bit 3 adds the destination value to the live destination pointer, and this takes precedence over mode bit 2. Mode bit 3 updates the destination even when mask bit 2 is clear.
- R5: The add form uses opcode 0x38 with mode bits in 20:18 and the value fields at the load form's positions. For each pointer whose mode bit is set, the value is added to the checkpoint and the sum is copied to the live pointer. Otherwise the value is added to the live pointer and the checkpoint is unchanged. All sums wrap.
- R6: An instruction changes only the thread named by thread_i. The pointer and address outputs always reflect the thread named by thread_i.
- R7: A load form with bank bit 22 set makes bank_rel_a_o high for exactly the next cycle, and bank bit 23 does the same for bank_rel_b_o. No other instruction produces a pulse.
- R8: The multiply-fetch A and B rows are the pointers with their low 3 bits cleared. The destination row is (pointer + dst_base_i + mm_field_i + thr_ofs_i) mod 1024 with its low 3 bits cleared.
- R9: For the vector access, addr = (vec_imm_i + thr_ofs_i + destination pointer + dst_base_i) mod 1024. The row is ((addr with low 2 bits cleared) + lane/8) mod 1024, and the column is (lane mod 8)*2 + addr bit 1.
- R10: A word with instr_valid_i low, or with an opcode other than 0x37 or 0x38, changes no pointer, no checkpoint and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 30 | Instruction word |
| thread_i | input | 2 | Thread for the instruction and for the outputs |
| dst_base_i | input | 10 | Destination base row |
| thr_ofs_i | input | 10 | Selected thread's destination offset |
| mm_field_i | input | 10 | Multiply instruction's destination offset field |
| vec_imm_i | input | 10 | Vector access immediate |
| vec_lane_i | input | 5 | Vector lane index 0..31 |
| cnt_a_o | output | 6 | Live operand A pointer of the selected thread |
| cnt_b_o | output | 6 | Live operand B pointer of the selected thread |
| cnt_d_o | output | 10 | Live destination pointer of the selected thread |
| mm_a_row_o | output | 6 | Multiply fetch row, operand A |
| mm_b_row_o | output | 6 | Multiply fetch row, operand B |
| mm_d_row_o | output | 10 | Multiply destination row |
| vec_row_o | output | 10 | Vector access row for the lane |
| vec_col_o | output | 4 | Vector access column for the lane |
| bank_rel_a_o | output | 1 | Operand A bank release-and-flip pulse |
| bank_rel_b_o | output | 1 | Operand B bank release-and-flip pulse |

## Verification
The assertions assume that thread_i names one of the three existing threads whenever instr_valid_i is high. They also assume that at most one instruction arrives per cycle, since the port carries only one word. The stimulus draws thread indices only from 0 to 2 and drives one word per cycle. Its opcode mix covers both forms, foreign opcodes and idle cycles. The checkpoint assertions rely on the load form always mirroring the live pointer into its checkpoint. That is why a checkpoint-relative add of zero can expose a checkpoint at the pointer outputs.

// File: rtl/rowctr_pkg.sv
package rowctr_pkg;
  localparam int VAL_W = 4;
  localparam logic [5:0] OP_SET = 6'h37;
  localparam logic [5:0] OP_INC = 6'h38;

  typedef enum logic [1:0] {UPD_NONE, UPD_SET, UPD_INC} upd_e;

  typedef struct packed {
    upd_e             kind;
    logic             rel_ckpt;
    logic             rel_live;
    logic [VAL_W-1:0] val;
  } upd_t;
endpackage

// File: rtl/rowctr_decode.sv
module rowctr_decode
  import rowctr_pkg::*;
(
  input  logic        valid_i,
  input  logic [29:0] word_i,
  output upd_t        upd_a_o,
  output upd_t        upd_b_o,
  output upd_t        upd_d_o,
  output logic        rel_a_o,
  output logic        rel_b_o
);
  logic [5:0] op;
  logic [1:0] bank;
  logic [3:0] mode;
  logic [5:0] mask;
  logic       is_set, is_inc;
  logic       unused_bits;

  assign op     = word_i[29:24];
  assign bank   = word_i[23:22];
  assign mode   = word_i[21:18];
  assign mask   = word_i[5:0];
  assign is_set = valid_i && (op == OP_SET);
  assign is_inc = valid_i && (op == OP_INC);
  assign rel_a_o = is_set && bank[0];
  assign rel_b_o = is_set && bank[1];
  assign unused_bits = ^mask[5:3];

  always_comb begin
    upd_a_o.kind     = is_set && mask[0] ? UPD_SET : (is_inc ? UPD_INC : UPD_NONE);
    upd_a_o.rel_ckpt = mode[0];
    upd_a_o.rel_live = 1'b0;
    upd_a_o.val      = word_i[9:6];

    upd_b_o.kind     = is_set && mask[1] ? UPD_SET : (is_inc ? UPD_INC : UPD_NONE);
    upd_b_o.rel_ckpt = mode[1];
    upd_b_o.rel_live = 1'b0;
    upd_b_o.val      = word_i[13:10];

    // mode bit 3 alone enables the destination load
    upd_d_o.kind     = is_set && (mask[2] || mode[3]) ? UPD_SET : (is_inc ? UPD_INC : UPD_NONE);
    upd_d_o.rel_ckpt = mode[2];
    upd_d_o.rel_live = is_set && mode[3];
    upd_d_o.val      = word_i[17:14];
  end
endmodule

// File: rtl/rowctr_cell.sv
module rowctr_cell
  import rowctr_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  upd_t         upd_i,
  output logic [W-1:0] live_o
);
  logic [W-1:0] live_q, ckpt_q, live_d, ckpt_d;
  logic [W-1:0] addend, base, sum_set;

  assign addend  = W'(upd_i.val);
  assign base    = upd_i.rel_live ? live_q : (upd_i.rel_ckpt ? ckpt_q : '0);
  assign sum_set = base + addend;

  always_comb begin
    live_d = live_q;
    ckpt_d = ckpt_q;
    if (sel_i) begin
      unique case (upd_i.kind)
        UPD_SET: begin
          live_d = sum_set;
          ckpt_d = sum_set;
        end
        UPD_INC: begin
          if (upd_i.rel_ckpt) begin
            ckpt_d = ckpt_q + addend;
            live_d = ckpt_q + addend;
          end else begin
            live_d = live_q + addend;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      ckpt_q <= '0;
    end else begin
      live_q <= live_d;
      ckpt_q <= ckpt_d;
    end
  end

  assign live_o = live_q;

  assert_set_mirror_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && upd_i.kind == UPD_SET |=> live_q == ckpt_q);

  assert_inc_ckpt_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && upd_i.kind == UPD_INC && upd_i.rel_ckpt |=> live_q == ckpt_q);

  assert_inc_ckpt_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && upd_i.kind == UPD_INC && !upd_i.rel_ckpt |=> $stable(ckpt_q));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i || upd_i.kind == UPD_NONE |=> $stable(live_q) && $stable(ckpt_q));
endmodule

// File: rtl/rowctr_addr.sv
module rowctr_addr #(
  parameter int SRC_W      = 6,
  parameter int DST_W      = 10,
  parameter int MM_ALIGN   = 3,
  parameter int VEC_ALIGN  = 2,
  parameter int LANE_W     = 5,
  parameter int LANE_COL_W = 3,
  localparam int COL_W     = LANE_COL_W + 1
) (
  input  logic [SRC_W-1:0]  a_i,
  input  logic [SRC_W-1:0]  b_i,
  input  logic [DST_W-1:0]  d_i,
  input  logic [DST_W-1:0]  base_i,
  input  logic [DST_W-1:0]  field_i,
  input  logic [DST_W-1:0]  ofs_i,
  input  logic [DST_W-1:0]  imm_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [SRC_W-1:0]  mm_a_o,
  output logic [SRC_W-1:0]  mm_b_o,
  output logic [DST_W-1:0]  mm_d_o,
  output logic [DST_W-1:0]  vec_row_o,
  output logic [COL_W-1:0]  vec_col_o
);
  logic [DST_W-1:0] mm_sum, vaddr, vbase;

  assign mm_a_o = {a_i[SRC_W-1:MM_ALIGN], {MM_ALIGN{1'b0}}};
  assign mm_b_o = {b_i[SRC_W-1:MM_ALIGN], {MM_ALIGN{1'b0}}};

  assign mm_sum = d_i + base_i + field_i + ofs_i;
  assign mm_d_o = {mm_sum[DST_W-1:MM_ALIGN], {MM_ALIGN{1'b0}}};

  assign vaddr     = imm_i + ofs_i + d_i + base_i;
  assign vbase     = {vaddr[DST_W-1:VEC_ALIGN], {VEC_ALIGN{1'b0}}};
  assign vec_row_o = vbase + DST_W'(lane_i[LANE_W-1:LANE_COL_W]);
  assign vec_col_o = {lane_i[LANE_COL_W-1:0], vaddr[1]};
endmodule

// File: rtl/rowctr_file.sv
module rowctr_file
  import rowctr_pkg::*;
#(
  parameter int  NUM_THREADS = 3,
  parameter int  SRC_W       = 6,
  parameter int  DST_W       = 10,
  localparam int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic [29:0]      instr_i,
  input  logic [TID_W-1:0] thread_i,
  input  logic [DST_W-1:0] dst_base_i,
  input  logic [DST_W-1:0] thr_ofs_i,
  input  logic [DST_W-1:0] mm_field_i,
  input  logic [DST_W-1:0] vec_imm_i,
  input  logic [4:0]       vec_lane_i,
  output logic [SRC_W-1:0] cnt_a_o,
  output logic [SRC_W-1:0] cnt_b_o,
  output logic [DST_W-1:0] cnt_d_o,
  output logic [SRC_W-1:0] mm_a_row_o,
  output logic [SRC_W-1:0] mm_b_row_o,
  output logic [DST_W-1:0] mm_d_row_o,
  output logic [DST_W-1:0] vec_row_o,
  output logic [3:0]       vec_col_o,
  output logic             bank_rel_a_o,
  output logic             bank_rel_b_o
);
  upd_t upd_a, upd_b, upd_d;
  logic rel_a, rel_b;
  logic rel_a_q, rel_b_q;

  logic [SRC_W-1:0] live_a [NUM_THREADS];
  logic [SRC_W-1:0] live_b [NUM_THREADS];
  logic [DST_W-1:0] live_d [NUM_THREADS];

  rowctr_decode u_decode (
    .valid_i (instr_valid_i),
    .word_i  (instr_i),
    .upd_a_o (upd_a),
    .upd_b_o (upd_b),
    .upd_d_o (upd_d),
    .rel_a_o (rel_a),
    .rel_b_o (rel_b)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic sel;
    assign sel = (thread_i == TID_W'(t));

    rowctr_cell #(.W(SRC_W)) u_a (
      .clk_i, .rst_ni, .sel_i(sel), .upd_i(upd_a), .live_o(live_a[t]));
    rowctr_cell #(.W(SRC_W)) u_b (
      .clk_i, .rst_ni, .sel_i(sel), .upd_i(upd_b), .live_o(live_b[t]));
    rowctr_cell #(.W(DST_W)) u_d (
      .clk_i, .rst_ni, .sel_i(sel), .upd_i(upd_d), .live_o(live_d[t]));
  end

  always_comb begin
    cnt_a_o = '0;
    cnt_b_o = '0;
    cnt_d_o = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (thread_i == TID_W'(t)) begin
        cnt_a_o = live_a[t];
        cnt_b_o = live_b[t];
        cnt_d_o = live_d[t];
      end
    end
  end

  rowctr_addr #(.SRC_W(SRC_W), .DST_W(DST_W)) u_addr (
    .a_i       (cnt_a_o),
    .b_i       (cnt_b_o),
    .d_i       (cnt_d_o),
    .base_i    (dst_base_i),
    .field_i   (mm_field_i),
    .ofs_i     (thr_ofs_i),
    .imm_i     (vec_imm_i),
    .lane_i    (vec_lane_i),
    .mm_a_o    (mm_a_row_o),
    .mm_b_o    (mm_b_row_o),
    .mm_d_o    (mm_d_row_o),
    .vec_row_o (vec_row_o),
    .vec_col_o (vec_col_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_a_q <= 1'b0;
      rel_b_q <= 1'b0;
    end else begin
      rel_a_q <= rel_a;
      rel_b_q <= rel_b;
    end
  end

  assign bank_rel_a_o = rel_a_q;
  assign bank_rel_b_o = rel_b_q;

  assert_thread_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i |-> int'(thread_i) < NUM_THREADS);

  assert_rel_a_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[29:24] == OP_SET && instr_i[22] |=> bank_rel_a_o);

  assert_rel_b_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[29:24] == OP_SET && instr_i[23] |=> bank_rel_b_o);

  assert_no_rel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(instr_valid_i && instr_i[29:24] == OP_SET) |=> !bank_rel_a_o && !bank_rel_b_o);
endmodule

// File: tb/rowctr_file_bench.sv
`timescale 1ns/1ps
module rowctr_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [29:0] word = '0;
  logic [1:0]  thr = '0;
  logic [9:0]  base = '0, ofs = '0, field = '0, imm = '0;
  logic [4:0]  lane = '0;
  logic [5:0]  cnt_a, cnt_b, mm_a, mm_b;
  logic [9:0]  cnt_d, mm_d, vrow;
  logic [3:0]  vcol;
  logic        rel_a, rel_b;

  always #4 clk = ~clk;

  rowctr_file u_rowctr_file (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(word),
    .thread_i(thr), .dst_base_i(base), .thr_ofs_i(ofs), .mm_field_i(field),
    .vec_imm_i(imm), .vec_lane_i(lane), .cnt_a_o(cnt_a), .cnt_b_o(cnt_b),
    .cnt_d_o(cnt_d), .mm_a_row_o(mm_a), .mm_b_row_o(mm_b), .mm_d_row_o(mm_d),
    .vec_row_o(vrow), .vec_col_o(vcol), .bank_rel_a_o(rel_a), .bank_rel_b_o(rel_b));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int la[3], lb[3], ld[3], ca[3], cb[3], cd[3];
  bit exp_ra = 0, exp_rb = 0;
  int prev_thr = 0;
  string prev_lbl = "R1";

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [29:0] mk_set(input int bank, mode, d, b, a, mask);
    return {6'h37, 2'(bank), 4'(mode), 4'(d), 4'(b), 4'(a), 6'(mask)};
  endfunction

  function automatic logic [29:0] mk_inc(input int mode, d, b, a);
    return {6'h38, 3'b0, 3'(mode), 4'(d), 4'(b), 4'(a), 6'b0};
  endfunction

  // behavioural reference: apply one accepted word to the model
  task automatic model(input bit v, input int t, input logic [29:0] w);
    int op, bank, mode, vd, vb, va, mask, bs;
    op = int'(w[29:24]); bank = int'(w[23:22]); mode = int'(w[21:18]);
    vd = int'(w[17:14]); vb = int'(w[13:10]); va = int'(w[9:6]); mask = int'(w[5:0]);
    exp_ra = 0; exp_rb = 0;
    if (!v || (op != 'h37 && op != 'h38)) begin prev_lbl = "R10"; return; end
    if (op == 'h37) begin
      exp_ra = bank[0]; exp_rb = bank[1];
      if (mask[0]) begin bs = mode[0] ? ca[t] : 0; la[t] = (bs + va) & 63; ca[t] = la[t]; end
      if (mask[1]) begin bs = mode[1] ? cb[t] : 0; lb[t] = (bs + vb) & 63; cb[t] = lb[t]; end
      if (mask[2] || mode[3]) begin
        bs = mode[3] ? ld[t] : (mode[2] ? cd[t] : 0);
        ld[t] = (bs + vd) & 1023; cd[t] = ld[t];
      end
      if (mode[3]) prev_lbl = "R4";
      else if ((mode & mask & 7) != 0) prev_lbl = "R3";
      else prev_lbl = "R2";
    end else begin
      if (mode[0]) begin ca[t] = (ca[t] + va) & 63; la[t] = ca[t]; end
      else la[t] = (la[t] + va) & 63;
      if (mode[1]) begin cb[t] = (cb[t] + vb) & 63; lb[t] = cb[t]; end
      else lb[t] = (lb[t] + vb) & 63;
      if (mode[2]) begin cd[t] = (cd[t] + vd) & 1023; ld[t] = cd[t]; end
      else ld[t] = (ld[t] + vd) & 1023;
      prev_lbl = "R5";
    end
  endtask

  // one clock: drive, compare visible state, then advance the model
  task automatic step(input bit v, input int t, input logic [29:0] w);
    int addr, sum, row, col;
    string lbl;
    @(negedge clk);
    valid = v; thr = 2'(t); word = w;
    base = 10'($urandom); ofs = 10'($urandom); field = 10'($urandom);
    imm = 10'($urandom); lane = 5'($urandom);
    #1;
    lbl = (t != prev_thr) ? "R6" : prev_lbl;
    chk(lbl, int'(cnt_a), la[t]);
    chk(lbl, int'(cnt_b), lb[t]);
    chk(lbl, int'(cnt_d), ld[t]);
    chk("R8", int'(mm_a), la[t] & 'h38);
    chk("R8", int'(mm_b), lb[t] & 'h38);
    sum = (ld[t] + int'(base) + int'(field) + int'(ofs)) & 1023;
    chk("R8", int'(mm_d), sum & 'h3f8);
    addr = (int'(imm) + int'(ofs) + ld[t] + int'(base)) & 1023;
    row = ((addr & 'h3fc) + int'(lane) / 8) & 1023;
    col = (int'(lane) % 8) * 2 + ((addr >> 1) & 1);
    chk("R9", int'(vrow), row);
    chk("R9", int'(vcol), col);
    chk("R7", int'(rel_a), int'(exp_ra));
    chk("R7", int'(rel_b), int'(exp_rb));
    prev_thr = t;
    model(v, t, w);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 3; t++) begin
      la[t] = 0; lb[t] = 0; ld[t] = 0; ca[t] = 0; cb[t] = 0; cd[t] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, checkpoints exposed by relative add of zero
    for (int t = 0; t < 3; t++) step(0, t, '0);
    for (int t = 0; t < 3; t++) step(1, t, mk_inc(7, 0, 0, 0));
    for (int t = 0; t < 3; t++) begin step(0, t, '0); prev_lbl = "R1"; end
    // R2 absolute loads and R6 isolation
    step(1, 1, mk_set(0, 0, 9, 7, 5, 7));
    step(0, 0, '0);
    step(0, 2, '0);
    step(0, 1, '0);
    // R5 live-only add then checkpoint add
    step(1, 1, mk_inc(0, 8, 8, 8));
    step(1, 1, mk_inc(7, 1, 1, 1));
    // R3 checkpoint-relative load, wrap on A
    for (int i = 0; i < 6; i++) step(1, 1, mk_set(0, 1, 0, 0, 15, 1));
    // R4 live-relative destination with mask bit 2 clear
    step(1, 1, mk_inc(0, 15, 0, 0));
    step(1, 1, mk_set(0, 12, 3, 0, 0, 0));
    // destination wrap at 1024
    for (int i = 0; i < 80; i++) step(1, 2, mk_inc(4, 15, 0, 0));
    // R7 bank pulses, then quiet cycle
    step(1, 0, mk_set(1, 0, 0, 0, 0, 0));
    step(1, 0, mk_set(2, 0, 0, 0, 0, 0));
    step(1, 0, mk_set(3, 0, 0, 0, 0, 0));
    step(0, 0, mk_set(3, 0, 0, 0, 0, 7));
    // R10 foreign opcode carrying bank bits
    step(1, 0, {6'h12, 24'hffffff});
    step(0, 0, '0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r, t;
      logic [29:0] w;
      r = int'($urandom % 10);
      t = int'($urandom % 3);
      w = 30'($urandom);
      if (r < 4) w[29:24] = 6'h37;
      else if (r < 8) w[29:24] = 6'h38;
      else if (w[29:24] == 6'h37 || w[29:24] == 6'h38) w[29:24] = 6'h00;
      step(($urandom % 8) != 0, t, w);
    end
    step(0, 0, '0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule